// File: doc/BRIEF.md
# CCD Vertical Field/Frame Sequencer

This block runs the vertical timing of an interline colour CCD. It counts horizontal line ticks within each vertical period and emits a one-cycle vertical sync at every period boundary. At each boundary it decides how the next readout is done.

It offers two accumulation styles. In monitoring style, each period reads adjacent row pairs mixed together. In still-capture style, whole frames are taken as two fields: the first field reads one row parity and the second reads the other. Before each first field, a fast charge sweep of the vertical register runs. Its length depends on the pixel-clock profile in use.

The block also places one overflow-drain shutter pulse at a programmable distance before the next readout. It raises a data-valid flag only for usable image lines. The line generator consumes the readout request and the parity select. The analog drivers stay outside this block.

Top module: `ccd_vseq`

## Requirements
- R1: Each `hd_i` tick advances `line_o`. The first tick after reset, and every tick that arrives while `line_o` is `V_LINES-1`, starts a new period. In the next cycle `line_o` is 0 and `vd_o` is high for exactly one cycle, so a period lasts `V_LINES` ticks.
- R2: In monitoring mode (`frame_mode_i`=0), `read_req_o` pulses once per period in the same cycle as `vd_o`, with `read_sel_o`=2'b11 (row pairs mixed).
- R3: In still-capture mode (`frame_mode_i`=1), the periods alternate. The first period after entering the mode reads `read_sel_o`=2'b01 (odd rows), the next reads 2'b10 (even rows), and the pattern repeats. Each period has one `read_req_o` pulse.
- R4: Every odd-row period starts with `sweep_o` high for exactly `SWEEP_SLOW` cycles (when `fast_profile_i`=0) or `SWEEP_FAST` cycles (when it is 1). The sweep begins in the `vd_o` cycle. The odd-row `read_req_o` fires in the cycle right after `sweep_o` falls. Even-row and monitoring periods have no sweep.
- R5: `fast_profile_i` is taken at the period boundary that starts the sweep.
- R6: In monitoring mode, exactly one `ofd_pulse_o` cycle occurs per period. It comes in the cycle where `line_o` becomes `V_LINES-N`, with N = `shutter_lines_i` clamped to the range 1..`V_LINES-1`.
- R7: No `ofd_pulse_o` occurs in still-capture periods.
- R8: `frame_mode_i` is taken only at a period boundary. A change in mid-period alters neither the readout select nor the sweep of that period.
- R9: The first period after reset, and the first period after any change of mode, keep `valid_o` low throughout.
- R10: In other periods, `valid_o` is high only while `line_o` is in `OB_FRONT`..`OB_FRONT+ACTIVE_LINES/2-1` and `sweep_o` is low. It is low on the optical-black lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | One-cycle line tick |
| frame_mode_i | input | 1 | 0 monitoring (mixed rows), 1 still capture |
| fast_profile_i | input | 1 | Selects the long sweep for the faster pixel clock |
| shutter_lines_i | input | $clog2(V_LINES) | Shutter distance in lines before readout |
| vd_o | output | 1 | One-cycle period start |
| line_o | output | $clog2(V_LINES) | Line index within the period |
| read_req_o | output | 1 | Readout transfer request |
| read_sel_o | output | 2 | Rows read: 01 odd, 10 even, 11 mixed pairs |
| sweep_o | output | 1 | Charge-sweep burst active, one stage per cycle |
| ofd_pulse_o | output | 1 | Overflow-drain shutter pulse |
| valid_o | output | 1 | Line carries usable image data |

## Verification
The bench targets the mode transitions. If a design resampled the mode in mid-period, the sweep or the select would change inside that period. If a design did not invalidate the transition period, `valid_o` would be high in the first odd-row field. The shutter clamp is tested at zero and above the period length: a design without the clamp would lose the pulse, or place it on the readout line. The sweep length is measured for both profiles, and the odd-row readout must follow the sweep in the very next cycle. A design that counted one stage too many, or that read before the flush ended, shows up as a wrong length or a missing request.

// File: rtl/ccd_vseq_pkg.sv
package ccd_vseq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_ODD  = 2'b01,
    SEL_EVEN = 2'b10,
    SEL_MIX  = 2'b11
  } rd_sel_e;
endpackage

// File: rtl/ccd_vline_cnt.sv
module ccd_vline_cnt #(
  parameter int V_LINES = 453,
  localparam int LW = $clog2(V_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hd_i,
  output logic [LW-1:0] line_o,
  output logic          last_o,
  output logic          vd_o
);
  localparam logic [LW-1:0] LAST = LW'(V_LINES - 1);

  logic [LW-1:0] line_q;
  logic          vd_q;

  assign last_o = hd_i && (line_q == LAST);
  assign line_o = line_q;
  assign vd_o   = vd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= LAST;
      vd_q   <= 1'b0;
    end else begin
      vd_q <= last_o;
      if (hd_i) line_q <= last_o ? '0 : line_q + 1'b1;
    end
  end

  // R1
  vd_line0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vd_o |-> line_q == '0);
endmodule

// File: rtl/ccd_sweep.sv
module ccd_sweep #(
  parameter int SWEEP_SLOW = 658,
  parameter int SWEEP_FAST = 668,
  localparam int SMAX = (SWEEP_FAST > SWEEP_SLOW) ? SWEEP_FAST : SWEEP_SLOW,
  localparam int SW   = $clog2(SMAX + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic fast_i,
  output logic busy_o,
  output logic done_o
);
  logic [SW-1:0] cnt_q;
  logic          done_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cnt_q == SW'(1)) && !start_i;
      if (start_i)      cnt_q <= fast_i ? SW'(SWEEP_FAST) : SW'(SWEEP_SLOW);
      else if (busy_o)  cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o) && !busy_o);
endmodule

// File: rtl/ccd_shutter.sv
module ccd_shutter #(
  parameter int V_LINES = 453,
  localparam int LW = $clog2(V_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hd_i,
  input  logic [LW-1:0] line_i,
  input  logic          en_i,
  input  logic [LW-1:0] lines_i,
  output logic          pulse_o
);
  localparam logic [LW-1:0] MAXS = LW'(V_LINES - 1);
  localparam logic [LW:0]   VL   = (LW+1)'(V_LINES);

  logic [LW-1:0] eff;
  logic [LW:0]   target, nxt;
  logic          pulse_q;

  always_comb begin
    if (lines_i == '0)       eff = LW'(1);
    else if (lines_i > MAXS) eff = MAXS;
    else                     eff = lines_i;
  end

  assign target  = VL - {1'b0, eff};
  assign nxt     = {1'b0, line_i} + 1'b1;
  assign pulse_o = pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= hd_i && en_i && (nxt == target);
  end

  // R6
  ofd_not_readout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> line_i != '0);
endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq
  import ccd_vseq_pkg::*;
#(
  parameter int V_LINES      = 453,
  parameter int ACTIVE_LINES = 884,
  parameter int OB_FRONT     = 7,
  parameter int SWEEP_SLOW   = 658,
  parameter int SWEEP_FAST   = 668,
  localparam int LW = $clog2(V_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hd_i,
  input  logic          frame_mode_i,
  input  logic          fast_profile_i,
  input  logic [LW-1:0] shutter_lines_i,
  output logic          vd_o,
  output logic [LW-1:0] line_o,
  output logic          read_req_o,
  output logic [1:0]    read_sel_o,
  output logic          sweep_o,
  output logic          ofd_pulse_o,
  output logic          valid_o
);
  localparam int            ROWS    = ACTIVE_LINES / 2;
  localparam logic [LW-1:0] D_FIRST = LW'(OB_FRONT);
  localparam logic [LW-1:0] D_LAST  = LW'(OB_FRONT + ROWS - 1);

  logic    last, sw_done, sw_start, nxt_phase;
  logic    mode_q, phase_q, started_q, field_ok_q, imm_q;
  rd_sel_e sel_q;

  ccd_vline_cnt #(.V_LINES(V_LINES)) u_line (
    .clk_i, .rst_ni, .hd_i, .line_o, .last_o(last), .vd_o);

  ccd_sweep #(.SWEEP_SLOW(SWEEP_SLOW), .SWEEP_FAST(SWEEP_FAST)) u_sweep (
    .clk_i, .rst_ni, .start_i(sw_start), .fast_i(fast_profile_i),
    .busy_o(sweep_o), .done_o(sw_done));

  ccd_shutter #(.V_LINES(V_LINES)) u_shut (
    .clk_i, .rst_ni, .hd_i, .line_i(line_o), .en_i(!mode_q),
    .lines_i(shutter_lines_i), .pulse_o(ofd_pulse_o));

  // phase 0 = odd rows (preceded by sweep), 1 = even rows
  assign nxt_phase = frame_mode_i && mode_q && !phase_q;
  assign sw_start  = last && frame_mode_i && !nxt_phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= 1'b0;
      phase_q    <= 1'b0;
      started_q  <= 1'b0;
      field_ok_q <= 1'b0;
      imm_q      <= 1'b0;
      sel_q      <= SEL_NONE;
    end else begin
      imm_q <= last && !sw_start;
      if (last) begin
        mode_q     <= frame_mode_i;
        phase_q    <= nxt_phase;
        started_q  <= 1'b1;
        field_ok_q <= started_q && (frame_mode_i == mode_q);
        sel_q      <= !frame_mode_i ? SEL_MIX : (nxt_phase ? SEL_EVEN : SEL_ODD);
      end
    end
  end

  assign read_req_o = imm_q | sw_done;
  assign read_sel_o = sel_q;
  assign valid_o    = field_ok_q && !sweep_o && (line_o >= D_FIRST) && (line_o <= D_LAST);

  // R2
  rd_at_vd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_req_o && read_sel_o != SEL_ODD) |-> vd_o);
  // R4
  rd_after_sweep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_req_o && read_sel_o == SEL_ODD) |-> $past(sweep_o) && !sweep_o);
  // R4
  sweep_at_vd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sweep_o) |-> vd_o);
  // R7
  ofd_mix_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofd_pulse_o |-> read_sel_o == SEL_MIX);
endmodule

// File: tb/sim_ccd_vseq.sv
module sim_ccd_vseq;
  localparam int VL = 20, ACT = 20, OBF = 3, SWS = 12, SWF = 16, HDP = 8;
  localparam int LW = $clog2(VL);

  logic clk = 1'b0, rst_n = 1'b0, hd = 1'b0, fmode = 1'b0, fast = 1'b0;
  logic [LW-1:0] shut = LW'(5);
  logic vd, rreq, sweep, ofd, valid;
  logic [1:0] rsel;
  logic [LW-1:0] line;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ccd_vseq #(.V_LINES(VL), .ACTIVE_LINES(ACT), .OB_FRONT(OBF),
             .SWEEP_SLOW(SWS), .SWEEP_FAST(SWF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .hd_i(hd), .frame_mode_i(fmode),
    .fast_profile_i(fast), .shutter_lines_i(shut), .vd_o(vd), .line_o(line),
    .read_req_o(rreq), .read_sel_o(rsel), .sweep_o(sweep),
    .ofd_pulse_o(ofd), .valid_o(valid));

  // per-period statistics: c_* current, l_* last completed
  int vd_cnt = 0, vd_line_bad = 0;
  int c_rd, c_sel, c_rdvd, c_sw, c_rdsw, c_ofd, c_ofdl, c_val, c_vbad, c_cyc;
  int l_rd, l_sel, l_rdvd, l_sw, l_rdsw, l_ofd, l_ofdl, l_val, l_vbad, l_cyc;
  logic prev_sw = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (vd) begin
        l_rd = c_rd; l_sel = c_sel; l_rdvd = c_rdvd; l_sw = c_sw; l_rdsw = c_rdsw;
        l_ofd = c_ofd; l_ofdl = c_ofdl; l_val = c_val; l_vbad = c_vbad; l_cyc = c_cyc;
        c_rd = 0; c_sel = -1; c_rdvd = 0; c_sw = 0; c_rdsw = 0;
        c_ofd = 0; c_ofdl = -1; c_val = 0; c_vbad = 0; c_cyc = 0;
        if (line != '0) vd_line_bad++;
        vd_cnt++;
      end
      c_cyc++;
      if (rreq) begin c_rd++; c_sel = int'(rsel); end
      if (rreq && vd) c_rdvd++;
      if (rreq && prev_sw && !sweep) c_rdsw++;
      if (sweep) c_sw++;
      if (ofd) begin c_ofd++; c_ofdl = int'(line); end
      if (valid) c_val++;
      if (valid && (line < LW'(OBF) || line > LW'(OBF + ACT/2 - 1) || sweep)) c_vbad++;
      prev_sw = sweep;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_vd();
    int t;
    t = vd_cnt + 1;
    wait (vd_cnt == t);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset vd", int'(vd), 0);
    check("R1 reset line", int'(line), VL - 1);
    check("R2 reset read", int'(rreq), 0);
    check("R4 reset sweep", int'(sweep), 0);
    check("R6 reset ofd", int'(ofd), 0);
    check("R9 reset valid", int'(valid), 0);
  endtask

  task automatic t_monitor_mode();
    next_vd(); next_vd();
    check("R9 first period invalid", l_val, 0);
    next_vd();
    check("R1 period length", l_cyc, VL * HDP);
    check("R1 vd at line 0", vd_line_bad, 0);
    check("R2 one read", l_rd, 1);
    check("R2 read at vd", l_rdvd, 1);
    check("R2 mixed select", l_sel, 3);
    check("R4 no sweep in monitoring", l_sw, 0);
    check("R6 one shutter", l_ofd, 1);
    check("R6 shutter line", l_ofdl, VL - 5);
    check("R10 valid cycles", l_val, (ACT / 2) * HDP);
    check("R10 valid only on data", l_vbad, 0);
  endtask

  task automatic t_shutter_clamp();
    shut = '0;
    next_vd();
    check("R6 clamp low line", l_ofdl, VL - 1);
    check("R6 clamp low count", l_ofd, 1);
    shut = LW'(25);
    next_vd();
    check("R6 clamp high line", l_ofdl, 1);
    check("R6 clamp high count", l_ofd, 1);
    shut = LW'(5);
  endtask

  task automatic t_frame_mode();
    repeat (40) @(negedge clk);
    fmode = 1'b1;
    next_vd();
    check("R8 mid change keeps select", l_sel, 3);
    check("R8 mid change no sweep", l_sw, 0);
    check("R8 mid change valid", l_val, (ACT / 2) * HDP);
    next_vd();
    check("R3 first odd", l_sel, 1);
    check("R3 one read", l_rd, 1);
    check("R4 slow sweep length", l_sw, SWS);
    check("R4 read after sweep", l_rdsw, 1);
    check("R7 no shutter", l_ofd, 0);
    check("R9 transition invalid", l_val, 0);
    fast = 1'b1;
    next_vd();
    check("R3 then even", l_sel, 2);
    check("R4 no sweep on even", l_sw, 0);
    check("R2 even read at vd", l_rdvd, 1);
    check("R10 even valid", l_val, (ACT / 2) * HDP);
    check("R7 no shutter even", l_ofd, 0);
    fmode = 1'b0;
    next_vd();
    check("R3 odd again", l_sel, 1);
    check("R5 fast sweep length", l_sw, SWF);
    check("R10 valid during sweep period", l_vbad, 0);
    check("R10 odd valid", l_val, (ACT / 2) * HDP);
  endtask

  task automatic t_back_to_monitor();
    next_vd();
    check("R9 return invalid", l_val, 0);
    check("R2 return mixed", l_sel, 3);
    check("R6 return shutter", l_ofd, 1);
    next_vd();
    check("R9 valid restored", l_val, (ACT / 2) * HDP);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        hd = 1'b1;
        @(negedge clk) hd = 1'b0;
        repeat (HDP - 2) @(negedge clk);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_monitor_mode();
    t_shutter_clamp();
    t_frame_mode();
    t_back_to_monitor();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule